// File: doc/BRIEF.md
# Parallel Word Serializer Master

This block carries a parallel word across a narrow serial link. When a frame starts, the master captures the low bits of its parallel input. It drives chip select low and toggles a serial clock derived from the system clock. It shifts the captured bits out on the data-out line, most significant bit first. At the same time it collects the bits the far end returns on the data-in line. When the frame closes, the collected bits appear together on a parallel output register, with a one-cycle done strobe.

The frame length can be set from 4 to 16 bits. Frames start on their own, without software action. A two-bit selector chooses what starts a frame: free-running, a change in the parallel word, a trigger edge, or a trigger edge that meets a changed word. A two-bit link configuration field must equal 01 before any frame can start.

Top module: `psx_master`

## Requirements
- R1: No frame starts (chip select stays high) unless `link_cfg` equals 2'b01. A frame already running completes.
- R2: The effective frame length L is `frame_len` clamped to the range 4..16. L is captured when the frame starts.
- R3: The transmitted bits are `par_in[L-1:0]`, most significant first, sampled when the frame starts. `mosi` changes only when `sck` falls or when chip select is asserted, never on a rising `sck`.
- R4: `miso` is sampled on each rising `sck`. At the end of the frame `par_out` takes the L received bits right-justified, first bit as bit L-1, with the upper bits zero. `par_out` changes only in the cycle where `done` is high.
- R5: With `start_mode` 2'b00 (free-running), the next frame starts one system cycle after the previous one closes. Chip select is high for exactly one cycle between frames.
- R6: With `start_mode` 2'b01 (on change), a frame starts only when `par_in[L-1:0]` differs from the word last transmitted. The last transmitted word is zero after reset.
- R7: With `start_mode` 2'b10 (on trigger), each rising edge of `trig` starts exactly one frame. A level held high starts only one frame. A rising edge during a frame is held and starts a frame after that frame closes.
- R8: With `start_mode` 2'b11 (trigger and change), a trigger edge starts a frame only if the word has changed. A trigger edge that finds no change is discarded. A change without a trigger starts nothing.
- R9: Each `sck` half-period lasts `half_div` system cycles, with 0 treated as 1, so the serial clock period is always an even number of cycles. Chip select falls one half-period before the first rising `sck` and rises one half-period after the last falling `sck`. `sck` is low whenever chip select is high.
- R10: During and right after reset: `cs_n`=1, `sck`=0, `mosi`=0, `done`=0, `par_out`=0.
- R11: `done` is a one-cycle pulse, high exactly in the cycle in which `cs_n` returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| link_cfg | input | 2 | Link configuration; 2'b01 enables the serializer |
| start_mode | input | 2 | 00 free-running, 01 on change, 10 on trigger, 11 trigger and change |
| frame_len | input | 5 | Requested frame length in bits (clamped to 4..16) |
| half_div | input | 8 | System cycles per serial clock half-period (0 acts as 1) |
| par_in | input | 16 | Parallel word to transmit |
| trig | input | 1 | Trigger, edge-detected |
| miso | input | 1 | Serial data returned by the far end |
| sck | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| par_out | output | 16 | Received word, right-justified |
| done | output | 1 | One-cycle strobe when `par_out` updates |

## Verification
The bench holds the trigger high across a whole frame. A design that works on the level instead of the edge would send frames without end. A second trigger arrives in the middle of a frame. A design that drops it would send one frame instead of two. In trigger-and-change mode, a trigger meets an unchanged word, and the word then changes with no trigger. A design that keeps the stale trigger would start a frame it should not. Requested lengths of 2 and 20 and a divider of 0 test the clamps; a design without them would send the wrong number of bits or stall with no clock edges. Every edge interval is timed, so a chip-select lead or trail that is missing or too long shows up.

// File: rtl/psx_pkg.sv
package psx_pkg;
  typedef enum logic [1:0] {
    START_FREE   = 2'b00,
    START_CHANGE = 2'b01,
    START_TRIG   = 2'b10,
    START_BOTH   = 2'b11
  } start_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_LOW   = 2'b01,
    PH_HIGH  = 2'b10,
    PH_TRAIL = 2'b11
  } phase_e;

  localparam logic [1:0] LINK_SERIAL = 2'b01;
endpackage

// File: rtl/psx_divider.sv
module psx_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] half_in,
  output logic             tick
);
  logic [DIV_W-1:0] half_q;
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == half_q - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      half_q <= DIV_W'(1);
    end else if (restart) begin
      cnt    <= '0;
      half_q <= (half_in == '0) ? DIV_W'(1) : half_in;
    end else if (run) begin
      cnt <= tick ? '0 : cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/psx_initiator.sv
module psx_initiator
  import psx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic              trig,
  input  logic              idle,
  input  logic [DATA_W-1:0] par_in,
  input  logic [LEN_W-1:0]  len,
  output logic              launch
);
  localparam logic [DATA_W:0] ONE = DATA_W'(1) + (DATA_W+1)'(0);

  logic              trig_q;
  logic              pend;
  logic [DATA_W-1:0] last_sent;
  logic [DATA_W:0]   mask_full;
  logic [DATA_W-1:0] mask;
  logic              changed;
  logic              trig_rise;
  logic              trig_mode;
  logic              want;

  assign mask_full = (ONE << len) - ONE;
  assign mask      = mask_full[DATA_W-1:0];
  assign changed   = ((par_in ^ last_sent) & mask) != '0;
  assign trig_rise = trig && !trig_q;
  assign trig_mode = (mode == START_TRIG) || (mode == START_BOTH);

  always_comb begin
    unique case (start_mode_e'(mode))
      START_FREE:   want = 1'b1;
      START_CHANGE: want = changed;
      START_TRIG:   want = pend;
      START_BOTH:   want = pend && changed;
      default:      want = 1'b0;
    endcase
  end

  assign launch = enable && idle && want;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q    <= 1'b0;
      pend      <= 1'b0;
      last_sent <= '0;
    end else begin
      trig_q <= trig;
      if (!enable || !trig_mode) pend <= 1'b0;
      else if (trig_rise)        pend <= 1'b1;
      else if (idle)             pend <= 1'b0;
      if (launch) last_sent <= par_in & mask;
    end
  end
endmodule

// File: rtl/psx_shifter.sv
module psx_shifter
  import psx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              tick,
  input  logic [DATA_W-1:0] par_in,
  input  logic [LEN_W-1:0]  len,
  input  logic              miso,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word,
  output logic              done,
  output logic              idle
);
  phase_e            phase;
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_sr;
  logic [LEN_W-1:0]  bits_left;
  logic [DATA_W-1:0] tx_load;

  assign tx_load = par_in << (LEN_W'(DATA_W) - len);
  assign mosi    = tx_sr[DATA_W-1];
  assign idle    = (phase == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      tx_sr     <= '0;
      rx_sr     <= '0;
      bits_left <= '0;
      sck       <= 1'b0;
      cs_n      <= 1'b1;
      rx_word   <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (launch) begin
            tx_sr     <= tx_load;
            rx_sr     <= '0;
            bits_left <= len;
            cs_n      <= 1'b0;
            phase     <= PH_LOW;
          end
        end
        PH_LOW: begin
          if (tick) begin
            sck       <= 1'b1;
            rx_sr     <= {rx_sr[DATA_W-2:0], miso};
            bits_left <= bits_left - LEN_W'(1);
            phase     <= PH_HIGH;
          end
        end
        PH_HIGH: begin
          if (tick) begin
            sck <= 1'b0;
            if (bits_left == '0) begin
              tx_sr <= '0;
              phase <= PH_TRAIL;
            end else begin
              tx_sr <= tx_sr << 1;
              phase <= PH_LOW;
            end
          end
        end
        PH_TRAIL: begin
          if (tick) begin
            cs_n    <= 1'b1;
            rx_word <= rx_sr;
            done    <= 1'b1;
            phase   <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/psx_master.sv
module psx_master
  import psx_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DIV_W   = 8,
  parameter int MIN_LEN = 4,
  parameter int LEN_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        link_cfg,
  input  logic [1:0]        start_mode,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [DATA_W-1:0] par_in,
  input  logic              trig,
  input  logic              miso,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  output logic [DATA_W-1:0] par_out,
  output logic              done
);
  localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(DATA_W);

  logic [LEN_W-1:0] len_eff;
  logic             launch;
  logic             tick;
  logic             idle;
  logic             enable;

  assign enable  = (link_cfg == LINK_SERIAL);
  assign len_eff = (frame_len < LEN_LO) ? LEN_LO :
                   (frame_len > LEN_HI) ? LEN_HI : frame_len;

  psx_initiator #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_init (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .mode   (start_mode),
    .trig   (trig),
    .idle   (idle),
    .par_in (par_in),
    .len    (len_eff),
    .launch (launch)
  );

  psx_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .restart (launch),
    .run     (!idle),
    .half_in (half_div),
    .tick    (tick)
  );

  psx_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .launch  (launch),
    .tick    (tick),
    .par_in  (par_in),
    .len     (len_eff),
    .miso    (miso),
    .sck     (sck),
    .cs_n    (cs_n),
    .mosi    (mosi),
    .rx_word (par_out),
    .done    (done),
    .idle    (idle)
  );
endmodule

// File: rtl/psx_master_chk.sv
module psx_master_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        link_cfg,
  input logic              sck,
  input logic              cs_n,
  input logic              mosi,
  input logic [DATA_W-1:0] par_out,
  input logic              done
);
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (link_cfg != 2'b01 && cs_n) |=> cs_n); // R1

  AST_MOSI_HELD_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(sck) |-> $stable(mosi)); // R3

  AST_OUT_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(par_out)); // R4

  AST_SCK_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck); // R9

  AST_DONE_AT_CS_RISE: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(cs_n)); // R11

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
endmodule

bind psx_master psx_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .link_cfg (link_cfg),
  .sck      (sck),
  .cs_n     (cs_n),
  .mosi     (mosi),
  .par_out  (par_out),
  .done     (done)
);

// File: tb/psx_master_test.sv
module psx_master_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  link_cfg = 2'b00;
  logic [1:0]  start_mode = 2'b00;
  logic [4:0]  frame_len = 5'd8;
  logic [7:0]  half_div = 8'd1;
  logic [15:0] par_in = 16'h0;
  logic        trig = 1'b0;
  logic        miso = 1'b0;
  logic        sck, cs_n, mosi, done;
  logic [15:0] par_out;

  always #5 clk = ~clk;

  psx_master uut (
    .clk(clk), .rst(rst), .link_cfg(link_cfg), .start_mode(start_mode),
    .frame_len(frame_len), .half_div(half_div), .par_in(par_in), .trig(trig),
    .miso(miso), .sck(sck), .cs_n(cs_n), .mosi(mosi), .par_out(par_out), .done(done)
  );

  typedef struct {
    logic [15:0] tx;
    logic [15:0] resp;
    int          len;
  } item_t;

  item_t exp_q[$];
  int n_checks = 0;
  int n_fail = 0;
  int frames_seen = 0;
  int exp_half = 1;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff_len(input int l);
    if (l < 4) return 4;
    if (l > 16) return 16;
    return l;
  endfunction

  function automatic logic [15:0] lmask(input int l);
    return 16'((32'h1 << l) - 1);
  endfunction

  task automatic push(input logic [15:0] tx, input logic [15:0] resp, input int len);
    item_t it;
    it.tx = tx & lmask(len);
    it.resp = resp;
    it.len = len;
    exp_q.push_back(it);
  endtask

  // monitor: plays the far end and scores each closed frame
  item_t cur;
  logic prev_sck = 1'b0, prev_cs = 1'b1;
  logic [15:0] tx_cap;
  int nbits, sbit, last_ev, bad_iv, cyc = 0;
  bit active = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (prev_cs && !cs_n) begin
        if (exp_q.size() == 0) begin
          check(0, "R1 unexpected frame", 1, 0);
          active = 0;
        end else begin
          cur = exp_q[0];
          active = 1;
        end
        nbits = 0; tx_cap = 0; bad_iv = 0; last_ev = cyc;
        sbit = cur.len - 1;
        miso = cur.resp[sbit];
      end else if (!cs_n && sck && !prev_sck) begin
        tx_cap = {tx_cap[14:0], mosi};
        nbits++;
        if (cyc - last_ev != exp_half) bad_iv++;
        last_ev = cyc;
      end else if (!cs_n && !sck && prev_sck) begin
        sbit--;
        if (sbit >= 0) miso = cur.resp[sbit];
        if (cyc - last_ev != exp_half) bad_iv++;
        last_ev = cyc;
      end else if (!prev_cs && cs_n) begin
        if (cyc - last_ev != exp_half) bad_iv++;
        frames_seen++;
        check(done === 1'b1, "R11 done with cs rise", done, 1);
        if (active) begin
          check(nbits == cur.len, "R2 bit count", nbits, cur.len);
          check(tx_cap == cur.tx, "R3 transmitted word", tx_cap, cur.tx);
          check(par_out == (cur.resp & lmask(cur.len)), "R4 received word",
                par_out, cur.resp & lmask(cur.len));
          check(bad_iv == 0, "R9 edge spacing", bad_iv, 0);
          void'(exp_q.pop_front());
        end
        active = 0;
      end
    end
    prev_sck = sck;
    prev_cs = cs_n;
  end

  task automatic wait_frames(input int target);
    int t = 0;
    while (frames_seen < target && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check(frames_seen >= target, "frame completion", frames_seen, target);
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", frames_seen, 0);
    finish_run();
  end

  initial begin
    int base;
    int k;
    repeat (4) @(negedge clk);
    // R10 reset state
    check(cs_n === 1'b1 && sck === 1'b0 && mosi === 1'b0 && done === 1'b0,
          "R10 outputs in reset", {cs_n, sck, mosi, done}, 4'b1000);
    rst = 1'b0;
    @(negedge clk);
    check(par_out === 16'h0 && cs_n === 1'b1, "R10 after reset", par_out, 0);

    // R1: wrong config keeps link silent even in free-running mode
    link_cfg = 2'b10; start_mode = 2'b00;
    repeat (100) @(negedge clk);
    check(frames_seen == 0 && cs_n, "R1 disabled", frames_seen, 0);
    link_cfg = 2'b00;

    // R7: trigger held high starts one frame
    start_mode = 2'b10; frame_len = 5'd8; half_div = 8'd2; exp_half = 2;
    par_in = 16'h12A5;
    push(16'h12A5, 16'h003C, 8);
    link_cfg = 2'b01;
    @(negedge clk); trig = 1'b1;
    wait_frames(1);
    repeat (300) @(negedge clk);
    check(frames_seen == 1, "R7 held trigger single frame", frames_seen, 1);
    trig = 1'b0;

    // R7: trigger during a frame is held for after it
    link_cfg = 2'b00; frame_len = 5'd12; half_div = 8'd1; exp_half = 1;
    par_in = 16'h0ABC;
    push(16'h0ABC, 16'h0F0F, 12);
    push(16'h0ABC, 16'h0963, 12);
    link_cfg = 2'b01;
    pulse_trig();
    while (cs_n) @(negedge clk);
    repeat (3) @(negedge clk);
    pulse_trig();
    wait_frames(3);
    repeat (200) @(negedge clk);
    check(frames_seen == 3, "R7 trigger latched in frame", frames_seen, 3);

    // R6: no change -> no frame, change -> one frame
    link_cfg = 2'b00; start_mode = 2'b01; frame_len = 5'd8; half_div = 8'd3; exp_half = 3;
    par_in = 16'h01BC;
    link_cfg = 2'b01;
    repeat (200) @(negedge clk);
    check(frames_seen == 3, "R6 unchanged word sends nothing", frames_seen, 3);
    push(16'h01C3, 16'h00A7, 8);
    par_in = 16'h01C3;
    wait_frames(4);
    repeat (200) @(negedge clk);
    check(frames_seen == 4, "R6 one frame per change", frames_seen, 4);

    // R8: trigger and change both needed
    link_cfg = 2'b00; start_mode = 2'b11; frame_len = 5'd16; half_div = 8'd2; exp_half = 2;
    par_in = 16'h00C3;
    link_cfg = 2'b01;
    pulse_trig();
    repeat (100) @(negedge clk);
    check(frames_seen == 4, "R8 trigger without change", frames_seen, 4);
    par_in = 16'hF00F;
    repeat (100) @(negedge clk);
    check(frames_seen == 4, "R8 change without trigger", frames_seen, 4);
    push(16'hF00F, 16'h5AA5, 16);
    pulse_trig();
    wait_frames(5);

    // R5 + R2 + R9: free-running, length 2 clamps to 4, divider 0 acts as 1
    link_cfg = 2'b00; start_mode = 2'b00; frame_len = 5'd2; half_div = 8'd0; exp_half = 1;
    par_in = 16'h0009;
    push(16'h0009, 16'h0006, eff_len(2));
    push(16'h0009, 16'h000B, eff_len(2));
    link_cfg = 2'b01;
    k = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
    check(cs_n === 1'b0, "R5 next frame one cycle later", cs_n, 0);
    while (!done) @(negedge clk);
    link_cfg = 2'b00;
    repeat (50) @(negedge clk);
    check(frames_seen == 7, "R5 two frames then stop", frames_seen, 7);

    // R2: length 20 clamps to 16
    base = frames_seen;
    start_mode = 2'b10; frame_len = 5'd20; half_div = 8'd1; exp_half = 1;
    par_in = 16'h8001;
    push(16'h8001, 16'h7FFE, eff_len(20));
    link_cfg = 2'b01;
    pulse_trig();
    wait_frames(base + 1);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R2 all expected frames seen", exp_q.size(), 0);
    finish_run();
  end
endmodule